// File: doc/BRIEF.md
# Channel Reference Soft-Start / Soft-Stop Sequencer

This block drives the reference code of one regulator channel during power-up and power-down. When the host raises the channel enable, the block waits a coarse delay and then raises the reference in fixed steps until it reaches the target code. When the host lowers the enable, the block waits a second coarse delay and then lowers the reference in fixed steps until it reaches the discharge threshold. The reference is then parked at zero.

Timing comes from a free-running microsecond tick. Each direction has its own 16-bit timing word. The upper six bits hold the pre-ramp delay in units of 250 ticks. The lower ten bits hold the number of ticks spent on each step. The reference code has a 10 mV LSB, so one 50 mV step moves it by 5 codes. Flags report a completed soft-start and a finished shutdown.

Top module: `chan_ramp_seq`

## Requirements
- R1: While reset is high, and on the edge that releases it, the reference is 0, `stopped` is 1 and `ss_done` is 0.
- R2: From the stopped or a falling state, the edge that samples `en` high begins the rise delay and clears `stopped`. The delay field is `rise_cfg[15:10]` = D, counted in units of 250 ticks. The delay ends on tick number D*250+1 after that edge, so D = 0 ends it on the very next tick.
- R3: During a ramp, a step occurs every S ticks, where S is the ramp word's bits [9:0]. The first step comes S ticks after the delay ends. S = 0 behaves as S = 1.
- R4: Each rising step adds 5 to the reference. The step that would reach or pass `target_code` sets the reference exactly to the target and sets `ss_done` on the same edge.
- R5: The edge that samples `en` low starts the fall delay from `fall_cfg[15:10]`, in 250-tick units as in R2. Falling steps then occur every `fall_cfg[9:0]` ticks, with 0 treated as 1, and each subtracts 5.
- R6: A falling step from a value at most 5 above `thr_code` ends the fall. The reference becomes the threshold, or keeps its value if it is already below the threshold, and `stopped` sets on that edge. On the next edge the reference goes to 0 and stays there while stopped.
- R7: `ss_done` clears on the edge that samples `en` low.
- R8: A change of `en` during a delay or a ramp abandons that phase on the sampling edge without moving the reference. The opposite sequence then starts from the present reference value. A change of `en` takes priority over a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Host channel enable |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rise_cfg | input | 16 | Rise delay [15:10], ticks per step [9:0] |
| fall_cfg | input | 16 | Fall delay [15:10], ticks per step [9:0] |
| target_code | input | 10 | Final reference of the rising ramp, 10 mV LSB |
| thr_code | input | 10 | Discharge threshold ending the falling ramp |
| vref_code | output | 10 | Reference code to the regulation loop |
| ss_done | output | 1 | Rising ramp reached the target |
| stopped | output | 1 | Falling ramp finished, reference parked at zero |

## Verification
Every change of the outputs is due a known number of ticks after the edge that samples a new `en` value. Flag and hold changes are due on that edge itself (offset 0). The first step is due at D*250+1+S ticks, and each later step S ticks after the one before. The zero-park is due one clock after the stop edge, with no tick in between. The bench records the tick count at the sampling edge and queues each expected output change together with its tick offset. A monitor samples on the falling clock edge, so every output change is judged on the cycle it appears. The monitor compares the value, both flags and the elapsed ticks, and it flags any change that has no queued entry.

// File: rtl/chan_ramp_pkg.sv
package chan_ramp_pkg;

    localparam int CFG_W  = 16;
    localparam int DLY_W  = 6;
    localparam int STEP_W = CFG_W - DLY_W;

    typedef struct packed {
        logic [DLY_W-1:0]  dly;
        logic [STEP_W-1:0] step;
    } ramp_cfg_t;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_RISE_WAIT,
        ST_RISE_RAMP,
        ST_AT_TGT,
        ST_FALL_WAIT,
        ST_FALL_RAMP
    } ramp_state_t;

    function automatic ramp_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
        ramp_cfg_t c;
        c.dly  = word[CFG_W-1:STEP_W];
        c.step = word[STEP_W-1:0];
        return c;
    endfunction

    function automatic logic [STEP_W-1:0] step_reload(input logic [STEP_W-1:0] s);
        return (s == '0) ? '0 : s - 1'b1;
    endfunction

endpackage

// File: rtl/ramp_tick_timer.sv
module ramp_tick_timer #(
    parameter int W           = 8,
    parameter bit AUTO_RELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] wrap_val;

    generate
        if (AUTO_RELOAD) begin : g_reload
            assign wrap_val = load_val;
        end else begin : g_hold
            assign wrap_val = '0;
        end
    endgenerate

    assign expire = tick && !load && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (cnt_q == '0) cnt_q <= wrap_val;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: the count only moves on a tick or a load
    a_r3_idle_count_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/ramp_code_step.sv
module ramp_code_step #(
    parameter int CODE_W     = 10,
    parameter int STEP_CODES = 5
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] thr,
    output logic [CODE_W-1:0] up_next,
    output logic              up_last,
    output logic [CODE_W-1:0] dn_next,
    output logic              dn_last
);
    localparam logic [CODE_W:0] STEP_X = (CODE_W+1)'(STEP_CODES);

    logic [CODE_W:0] up_sum;
    logic [CODE_W:0] thr_plus;

    assign up_sum   = {1'b0, cur} + STEP_X;
    assign thr_plus = {1'b0, thr} + STEP_X;

    always_comb begin
        if (up_sum >= {1'b0, target}) begin
            up_next = target;
            up_last = 1'b1;
        end else begin
            up_next = up_sum[CODE_W-1:0];
            up_last = 1'b0;
        end
    end

    always_comb begin
        if ({1'b0, cur} > thr_plus) begin
            dn_next = cur - STEP_X[CODE_W-1:0];
            dn_last = 1'b0;
        end else if (cur >= thr) begin
            dn_next = thr;
            dn_last = 1'b1;
        end else begin
            dn_next = cur;
            dn_last = 1'b1;
        end
    end

endmodule

// File: rtl/chan_ramp_seq.sv
module chan_ramp_seq
    import chan_ramp_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int STEP_CODES = 5,
    parameter int DLY_UNIT   = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              us_tick,
    input  logic [CFG_W-1:0]  rise_cfg,
    input  logic [CFG_W-1:0]  fall_cfg,
    input  logic [CODE_W-1:0] target_code,
    input  logic [CODE_W-1:0] thr_code,
    output logic [CODE_W-1:0] vref_code,
    output logic              ss_done,
    output logic              stopped
);
    localparam int DLY_MAX   = ((1 << DLY_W) - 1) * DLY_UNIT;
    localparam int DLY_CNT_W = $clog2(DLY_MAX + 1);

    ramp_cfg_t rise_c, fall_c;
    assign rise_c = unpack_cfg(rise_cfg);
    assign fall_c = unpack_cfg(fall_cfg);

    ramp_state_t       st_q, st_n;
    logic [CODE_W-1:0] vref_q, vref_n;
    logic              done_q, done_n, stop_q, stop_n;

    logic                 dly_exp, step_exp;
    logic                 dly_load, step_load;
    logic [DLY_CNT_W-1:0] dly_val;
    logic [STEP_W-1:0]    step_val;
    logic [CODE_W-1:0]    up_next, dn_next;
    logic                 up_last, dn_last;
    logic                 rising_n;

    ramp_code_step #(.CODE_W(CODE_W), .STEP_CODES(STEP_CODES)) u_step (
        .cur(vref_q), .target(target_code), .thr(thr_code),
        .up_next(up_next), .up_last(up_last),
        .dn_next(dn_next), .dn_last(dn_last)
    );

    always_comb begin
        st_n   = st_q;
        vref_n = vref_q;
        done_n = done_q;
        stop_n = stop_q;
        unique case (st_q)
            ST_STOP: begin
                vref_n = '0;
                if (en) begin
                    st_n   = ST_RISE_WAIT;
                    stop_n = 1'b0;
                end
            end
            ST_RISE_WAIT: begin
                if (!en)          st_n = ST_FALL_WAIT;
                else if (dly_exp) st_n = ST_RISE_RAMP;
            end
            ST_RISE_RAMP: begin
                if (!en) begin
                    st_n = ST_FALL_WAIT;
                end else if (step_exp) begin
                    vref_n = up_next;
                    if (up_last) begin
                        st_n   = ST_AT_TGT;
                        done_n = 1'b1;
                    end
                end
            end
            ST_AT_TGT: begin
                if (!en) begin
                    st_n   = ST_FALL_WAIT;
                    done_n = 1'b0;
                end
            end
            ST_FALL_WAIT: begin
                if (en)           st_n = ST_RISE_WAIT;
                else if (dly_exp) st_n = ST_FALL_RAMP;
            end
            ST_FALL_RAMP: begin
                if (en) begin
                    st_n = ST_RISE_WAIT;
                end else if (step_exp) begin
                    vref_n = dn_next;
                    if (dn_last) begin
                        st_n   = ST_STOP;
                        stop_n = 1'b1;
                    end
                end
            end
            default: st_n = ST_STOP;
        endcase
    end

    assign dly_load  = (st_n != st_q) &&
                       (st_n == ST_RISE_WAIT || st_n == ST_FALL_WAIT);
    assign step_load = (st_n != st_q) &&
                       (st_n == ST_RISE_RAMP || st_n == ST_FALL_RAMP);
    assign rising_n  = (st_n == ST_RISE_WAIT) || (st_n == ST_RISE_RAMP);

    assign dly_val  = rising_n ? DLY_CNT_W'(rise_c.dly) * DLY_CNT_W'(DLY_UNIT)
                               : DLY_CNT_W'(fall_c.dly) * DLY_CNT_W'(DLY_UNIT);
    assign step_val = rising_n ? step_reload(rise_c.step)
                               : step_reload(fall_c.step);

    ramp_tick_timer #(.W(DLY_CNT_W), .AUTO_RELOAD(1'b0)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val),
        .tick(us_tick), .expire(dly_exp)
    );

    ramp_tick_timer #(.W(STEP_W), .AUTO_RELOAD(1'b1)) u_pace (
        .clk(clk), .rst(rst), .load(step_load), .load_val(step_val),
        .tick(us_tick), .expire(step_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_STOP;
            vref_q <= '0;
            done_q <= 1'b0;
            stop_q <= 1'b1;
        end else begin
            st_q   <= st_n;
            vref_q <= vref_n;
            done_q <= done_n;
            stop_q <= stop_n;
        end
    end

    assign vref_code = vref_q;
    assign ss_done   = done_q;
    assign stopped   = stop_q;

    // R4: a rising ramp never moves down and never moves by more than one step
    a_r4_rise_bounded_step: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RISE_RAMP && en && up_next >= vref_q) |=>
            (vref_q >= $past(vref_q)) &&
            ((vref_q - $past(vref_q)) <= CODE_W'(STEP_CODES)));

    // R6: a falling ramp never raises the reference
    a_r6_fall_monotonic: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FALL_RAMP) |=> (vref_q <= $past(vref_q)));

    // R6: once stopped for a cycle the reference sits at zero
    a_r6_stopped_parks_zero: assert property (@(posedge clk) disable iff (rst)
        (stopped && $past(stopped)) |-> (vref_code == '0));

    // R7: a low enable always leaves the done flag clear
    a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ss_done);

    // R8: a reversal mid-fall does not move the reference on that edge
    a_r8_reverse_holds_code: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FALL_RAMP && en) |=> $stable(vref_q));

    // R4, R6: the two flags are never high together
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ss_done && stopped));

endmodule

// File: tb/chan_ramp_seq_test.sv
module chan_ramp_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        us_tick = 1'b0;
    logic [15:0] rise_cfg = '0;
    logic [15:0] fall_cfg = '0;
    logic [9:0]  target_code = '0;
    logic [9:0]  thr_code = '0;
    logic [9:0]  vref_code;
    logic        ss_done;
    logic        stopped;

    chan_ramp_seq uut (
        .clk(clk), .rst(rst), .en(en), .us_tick(us_tick),
        .rise_cfg(rise_cfg), .fall_cfg(fall_cfg),
        .target_code(target_code), .thr_code(thr_code),
        .vref_code(vref_code), .ss_done(ss_done), .stopped(stopped)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [9:0]  code;
        logic        done;
        logic        stp;
        logic [31:0] off;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int checks = 0;
    int bad = 0;
    int tick_cnt = 0;
    int base = 0;
    int phase = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always @(negedge clk) begin
        phase <= (phase == 2) ? 0 : phase + 1;
        us_tick <= (phase == 2);
    end

    always @(posedge clk) if (us_tick) tick_cnt <= tick_cnt + 1;

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic push(input logic [9:0] c, input logic d, input logic s,
                        input int off, input string req);
        exp_t e;
        e.code = c; e.done = d; e.stp = s; e.off = off;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en = v;
        @(posedge clk);
        #1 base = tick_cnt;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic settle();
        drain();
        repeat (10) @(negedge clk);
    endtask

    // monitor: every output change must match the next queued item
    logic [9:0] p_code;
    logic       p_done, p_stp;
    always @(negedge clk) begin
        if (mon_on) begin
            if (vref_code !== p_code || ss_done !== p_done || stopped !== p_stp) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", $sformatf(
                        "unexpected change act=%0d/%0b/%0b exp=no change",
                        vref_code, ss_done, stopped));
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(vref_code === e.code && ss_done === e.done &&
                          stopped === e.stp && (tick_cnt - base) == int'(e.off), t,
                          $sformatf("act code=%0d done=%0b stp=%0b off=%0d exp code=%0d done=%0b stp=%0b off=%0d",
                                    vref_code, ss_done, stopped, tick_cnt - base,
                                    e.code, e.done, e.stp, e.off));
                end
            end
        end
        p_code <= vref_code;
        p_done <= ss_done;
        p_stp  <= stopped;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(vref_code == 0 && stopped && !ss_done, "R1",
              $sformatf("reset act=%0d/%0b/%0b exp=0/0/1", vref_code, ss_done, stopped));
        rst = 1'b0;
        @(negedge clk);
        check(vref_code == 0 && stopped && !ss_done, "R1",
              $sformatf("after release act=%0d/%0b/%0b exp=0/0/1", vref_code, ss_done, stopped));
        mon_on = 1'b1;

        // R2, R4: delay of one unit, three ticks per step, target off the step grid
        rise_cfg = {6'd1, 10'd3}; fall_cfg = {6'd0, 10'd2};
        target_code = 10'd23; thr_code = 10'd7;
        push(0, 0, 0, 0, "R2");
        push(5, 0, 0, 254, "R2");
        push(10, 0, 0, 257, "R3");
        push(15, 0, 0, 260, "R3");
        push(20, 0, 0, 263, "R4");
        push(23, 1, 0, 266, "R4");
        set_en(1'b1);
        settle();

        // R5, R6, R7: fall with no delay, two ticks per step
        push(23, 0, 0, 0, "R7");
        push(18, 0, 0, 3, "R5");
        push(13, 0, 0, 5, "R5");
        push(8, 0, 0, 7, "R5");
        push(7, 0, 1, 9, "R6");
        push(0, 0, 1, 9, "R6");
        set_en(1'b0);
        settle();

        // R3: zero step field behaves as one tick
        rise_cfg = {6'd0, 10'd0}; target_code = 10'd12;
        push(0, 0, 0, 0, "R2");
        push(5, 0, 0, 2, "R3");
        push(10, 0, 0, 3, "R3");
        push(12, 1, 0, 4, "R4");
        set_en(1'b1);
        settle();

        fall_cfg = {6'd0, 10'd0};
        push(12, 0, 0, 0, "R7");
        push(7, 0, 1, 2, "R6");
        push(0, 0, 1, 2, "R6");
        set_en(1'b0);
        settle();

        // R8: disable in the middle of a rising ramp
        rise_cfg = {6'd0, 10'd4}; target_code = 10'd40;
        push(0, 0, 0, 0, "R2");
        push(5, 0, 0, 5, "R3");
        push(10, 0, 0, 9, "R3");
        set_en(1'b1);
        drain();
        push(7, 0, 1, 2, "R8");
        push(0, 0, 1, 2, "R8");
        set_en(1'b0);
        settle();

        // R8, R6: disable during the rise delay, reference below threshold
        rise_cfg = {6'd1, 10'd1};
        push(0, 0, 0, 0, "R2");
        set_en(1'b1);
        drain();
        repeat (20) @(negedge clk);
        push(0, 0, 1, 2, "R6");
        set_en(1'b0);
        settle();

        // R8: re-enable in the middle of a falling ramp
        rise_cfg = {6'd0, 10'd0}; target_code = 10'd30; fall_cfg = {6'd0, 10'd5};
        push(0, 0, 0, 0, "R2");
        push(5, 0, 0, 2, "R4");
        push(10, 0, 0, 3, "R4");
        push(15, 0, 0, 4, "R4");
        push(20, 0, 0, 5, "R4");
        push(25, 0, 0, 6, "R4");
        push(30, 1, 0, 7, "R4");
        set_en(1'b1);
        settle();
        push(30, 0, 0, 0, "R7");
        push(25, 0, 0, 6, "R5");
        push(20, 0, 0, 11, "R5");
        set_en(1'b0);
        drain();
        push(25, 0, 0, 2, "R8");
        push(30, 1, 0, 3, "R8");
        set_en(1'b1);
        settle();

        // R5: fall delay of one unit with unit step time
        fall_cfg = {6'd1, 10'd0};
        push(30, 0, 0, 0, "R7");
        push(25, 0, 0, 252, "R5");
        push(20, 0, 0, 253, "R5");
        push(15, 0, 0, 254, "R5");
        push(10, 0, 0, 255, "R5");
        push(7, 0, 1, 256, "R6");
        push(0, 0, 1, 256, "R6");
        set_en(1'b0);
        settle();

        check(exp_q.size() == 0, "R6",
              $sformatf("leftover act=%0d exp=0", exp_q.size()));
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL R8: watchdog act=running exp=finished, %0d items pending", exp_q.size());
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule